// File: doc/BRIEF.md
# Ladder Synchronous Start Sequencer

This block brings several sensor chips that share one ladder into lock-step readout. It does not try to sample a start strobe against a clock that is already running. It keeps the fast readout clock stopped until every chip has been reset and configured. It then releases that clock cleanly, so that every chip sees the same first edge. Only after the clock has run for a short settle interval does it issue a single start pulse.

The bring-up order is fixed. A `go_i` command asserts a common sensor reset for a programmable number of cycles. The sequencer then waits for the slow-control side to report, through `cfg_done_i`, that configuration is loaded. Next it opens the readout clock gate. The gate enable is held in a flip-flop clocked on the falling edge, so the enable moves only while the clock is low and the first gated high phase is a complete half period. After `SETTLE_CYCLES` running cycles it drives `start_o` for exactly one clock period, launched on a falling edge, and goes to the run state with the clock left running. The sensor reset is a slow control signal and need not meet any fast-clock timing at the chips.

`busy_o` marks the sequence in progress, and `go_i` is ignored while it is high. A `go_i` given in the run state starts the whole sequence again.

Top module: `ladder_start_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, and in the idle state after reset, `sensor_rst_o`, `rdclk_en_o`, `start_o` and `busy_o` are 0 and `rdclk_o` stays low.
- R2: A `go_i` high at a rising edge while `busy_o` is 0 raises `busy_o` and `sensor_rst_o` from that edge. `sensor_rst_o` stays high for exactly `RST_CYCLES` clock periods.
- R3: After the reset pulse ends, the block waits as long as `cfg_done_i` (a level) stays low, with `rdclk_en_o` held at 0. `cfg_done_i` passes through a two-stage synchronizer. `rdclk_en_o` rises on the falling edge that follows the third rising edge that samples `cfg_done_i` high, but never before the second falling edge after `sensor_rst_o` drops.
- R4: `rdclk_en_o` changes only on falling clock edges, that is while `clk` is low. `rdclk_o` is `clk` AND `rdclk_en_o`, and every high phase of `rdclk_o` lasts a full half period.
- R5: `start_o` rises on the falling edge `1 + SETTLE_CYCLES` clock periods after `rdclk_en_o` rises. It is high for exactly one clock period, and only while `rdclk_en_o` is 1.
- R6: `busy_o` stays 1 from the accepting edge until the rising edge that ends the start pulse. A `go_i` seen while `busy_o` is 1 has no effect on any output.
- R7: After the start pulse the block runs with `rdclk_en_o` 1, `start_o` 0 and `busy_o` 0. A `go_i` in this state restarts the sequence: `sensor_rst_o` rises at that edge and `rdclk_en_o` drops at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast readout clock source |
| rst_n | input | 1 | Synchronous active-low block reset |
| go_i | input | 1 | Request to run the bring-up sequence |
| cfg_done_i | input | 1 | Configuration-loaded level from slow control, asynchronous |
| sensor_rst_o | output | 1 | Common reset to all sensors, active high |
| rdclk_en_o | output | 1 | Readout clock gate enable, falling-edge registered |
| rdclk_o | output | 1 | Gated readout clock to the sensors |
| start_o | output | 1 | One-period start pulse, falling-edge launched |
| busy_o | output | 1 | Sequence in progress; new go ignored |

## Verification
The hardest behaviours to reach are the interaction of the configuration handshake with the reset pulse and a go command that arrives while the block is busy. The stimulus table varies the cycle at which `cfg_done_i` rises. In some rows it is raised before the go, or while reset is still active, so that the synchronizer is already full and the wait collapses to its one-cycle minimum. In other rows it is held low for a long stretch. Most rows also pulse `go_i` in the middle of the sequence, and each row after the first begins from the run state, which exercises the restart path. A monitor on the gated clock checks the width of each high phase and the clock level at each enable change.

// File: rtl/ladder_start_pkg.sv
// Shared types for the ladder start sequencer.
package ladder_start_pkg;

    // Bring-up phases, in the order they are visited.
    typedef enum logic [2:0] {
        SEQ_IDLE     = 3'd0,
        SEQ_RESET    = 3'd1,
        SEQ_WAIT_CFG = 3'd2,
        SEQ_CLK_EN   = 3'd3,
        SEQ_SETTLE   = 3'd4,
        SEQ_START    = 3'd5,
        SEQ_RUN      = 3'd6
    } seq_state_t;

endpackage

// File: rtl/lss_sync.sv
// Multi-stage level synchronizer for the slow-control handshake.
// Assumes: input is a level that stays stable for several cycles; STAGES >= 2.
module lss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lss_timer.sv
// Down-counting phase timer, loaded by the FSM and flagged at zero.
// Assumes: the FSM never asks for a decrement when the count is zero.
module lss_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load takes priority over decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (dec_i)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lss_fsm.sv
// Bring-up state machine: reset, wait for config, open clock, settle, start, run.
// Assumes: cfg_sync_i is already synchronized; RST_CYCLES, SETTLE_CYCLES >= 1.
module lss_fsm
    import ladder_start_pkg::*;
#(
    parameter int RST_CYCLES    = 16,
    parameter int SETTLE_CYCLES = 4,
    parameter int CNT_W         = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             cfg_sync_i,
    input  logic             tmr_zero_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             tmr_dec_o,
    output logic             sensor_rst_o,
    output logic             en_req_o,
    output logic             start_req_o,
    output logic             busy_o
);
    localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(RST_CYCLES - 1);
    localparam logic [CNT_W-1:0] SET_LOAD = CNT_W'(SETTLE_CYCLES - 1);

    seq_state_t state_q, state_d;
    logic       sensor_rst_q;

    // Next-state and timer control decode.
    always_comb begin
        state_d    = state_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        tmr_dec_o  = 1'b0;
        case (state_q)
            SEQ_IDLE, SEQ_RUN: begin
                if (go_i) begin
                    state_d    = SEQ_RESET;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = RST_LOAD;
                end
            end
            SEQ_RESET: begin
                if (tmr_zero_i) state_d = SEQ_WAIT_CFG;
                else            tmr_dec_o = 1'b1;
            end
            SEQ_WAIT_CFG: begin
                if (cfg_sync_i) state_d = SEQ_CLK_EN;
            end
            SEQ_CLK_EN: begin
                state_d    = SEQ_SETTLE;
                tmr_load_o = 1'b1;
                tmr_val_o  = SET_LOAD;
            end
            SEQ_SETTLE: begin
                if (tmr_zero_i) state_d = SEQ_START;
                else            tmr_dec_o = 1'b1;
            end
            SEQ_START: state_d = SEQ_RUN;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    // State register and registered sensor reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= SEQ_IDLE;
            sensor_rst_q <= 1'b0;
        end else begin
            state_q      <= state_d;
            sensor_rst_q <= (state_d == SEQ_RESET);
        end
    end

    assign sensor_rst_o = sensor_rst_q;
    assign en_req_o     = (state_q == SEQ_CLK_EN) || (state_q == SEQ_SETTLE) ||
                          (state_q == SEQ_START)  || (state_q == SEQ_RUN);
    assign start_req_o  = (state_q == SEQ_START);
    assign busy_o       = (state_q != SEQ_IDLE) && (state_q != SEQ_RUN);

    // R2: the reset phase cannot end before the timer expires.
    assert_reset_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RESET && !tmr_zero_i) |=> (state_q == SEQ_RESET));

    // R3: without a synchronized config flag the wait phase holds.
    assert_wait_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_WAIT_CFG && !cfg_sync_i) |=> (state_q == SEQ_WAIT_CFG));

    // R3: the clock request only rises after the config flag was seen.
    assert_en_after_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_req_o) |-> $past(cfg_sync_i));

    // R6: go during a busy phase never restarts the reset.
    assert_busy_ignores_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_q != SEQ_RESET && go_i) |=> (state_q != SEQ_RESET));
endmodule

// File: rtl/lss_negedge_out.sv
// Falling-edge output stage: registers the clock-gate enable and the start
// pulse on the falling edge and forms the gated readout clock.
// Assumes: requests come from rising-edge logic and are stable at the falling edge.
module lss_negedge_out (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req_i,
    input  logic start_req_i,
    output logic rdclk_en_o,
    output logic rdclk_o,
    output logic start_o
);
    logic en_q;
    logic start_q;

    // Move enable and start only while the clock is low.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            start_q <= 1'b0;
        end else begin
            en_q    <= en_req_i;
            start_q <= start_req_i;
        end
    end

    assign rdclk_en_o = en_q;
    assign rdclk_o    = clk & en_q;
    assign start_o    = start_q;

    // R5: start lasts a single period.
    assert_start_one_R5: assert property (@(negedge clk) disable iff (!rst_n)
        start_q |=> !start_q);

    // R5: start is only issued with the readout clock running.
    assert_start_needs_en_R5: assert property (@(negedge clk) disable iff (!rst_n)
        start_q |-> en_q);
endmodule

// File: rtl/ladder_start_seq.sv
// Top of the ladder synchronous start sequencer: synchronizer, phase timer,
// bring-up FSM and falling-edge output stage.
// Assumes: rst_n is synchronous to clk; cfg_done_i is an asynchronous level.
module ladder_start_seq #(
    parameter int RST_CYCLES    = 16,
    parameter int SETTLE_CYCLES = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic cfg_done_i,
    output logic sensor_rst_o,
    output logic rdclk_en_o,
    output logic rdclk_o,
    output logic start_o,
    output logic busy_o
);
    localparam int MAX_CNT = (RST_CYCLES > SETTLE_CYCLES) ? RST_CYCLES : SETTLE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    logic             cfg_sync;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_dec;
    logic             tmr_zero;
    logic             en_req;
    logic             start_req;

    lss_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cfg_done_i),
        .q_o   (cfg_sync)
    );

    lss_timer #(.CNT_W(CNT_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .dec_i      (tmr_dec),
        .zero_o     (tmr_zero)
    );

    lss_fsm #(
        .RST_CYCLES    (RST_CYCLES),
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .CNT_W         (CNT_W)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (go_i),
        .cfg_sync_i   (cfg_sync),
        .tmr_zero_i   (tmr_zero),
        .tmr_load_o   (tmr_load),
        .tmr_val_o    (tmr_val),
        .tmr_dec_o    (tmr_dec),
        .sensor_rst_o (sensor_rst_o),
        .en_req_o     (en_req),
        .start_req_o  (start_req),
        .busy_o       (busy_o)
    );

    lss_negedge_out out_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_req_i    (en_req),
        .start_req_i (start_req),
        .rdclk_en_o  (rdclk_en_o),
        .rdclk_o     (rdclk_o),
        .start_o     (start_o)
    );
endmodule

// File: tb/ladder_start_seq_tb_top.sv
// Bench: table of configuration timings and mid-sequence go pulses, each with
// the expected wait length, then directed reset tests. Outputs are sampled
// just after the falling edge; inputs change at that same point.
module ladder_start_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RST_N_CYC  = 3;
    localparam int SET_N_CYC  = 2;
    localparam int NROWS      = 6;
    // cfg_done raise point (sample index, -1 = with go), go pulse index
    // (-1 = none), expected wait-phase length in samples.
    localparam int ROW_CFG  [NROWS] = '{-1, 0, 2, 9, 5, 40};
    localparam int ROW_GO   [NROWS] = '{-1, 1, 4, 6, -1, 20};
    localparam int ROW_WAIT [NROWS] = '{ 1, 1, 2, 9, 5, 40};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic cfg = 1'b0;
    logic sensor_rst, rdclk_en, rdclk, start, busy;
    int   n_checks = 0;
    int   n_fail = 0;
    logic rise_ok = 1'b0;
    longint t_rise = 0;

    ladder_start_seq #(
        .RST_CYCLES    (RST_N_CYC),
        .SETTLE_CYCLES (SET_N_CYC),
        .SYNC_STAGES   (2)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (go),
        .cfg_done_i   (cfg),
        .sensor_rst_o (sensor_rst),
        .rdclk_en_o   (rdclk_en),
        .rdclk_o      (rdclk),
        .start_o      (start),
        .busy_o       (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check4(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {sensor_rst, rdclk_en, start, busy};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {rst,en,start,busy} got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // R4: the enable must only move while clk is low.
    always @(rdclk_en) begin
        if ($time > 0) begin
            n_checks++;
            if (clk !== 1'b0) begin
                n_fail++;
                $display("FAIL R4: enable changed with clk=%b expected 0", clk);
            end
        end
    end

    // R4: every gated high phase must be a full half period.
    always @(posedge rdclk) begin
        if (rdclk === 1'b1 && rdclk_en === 1'b1) begin
            t_rise  = longint'($time);
            rise_ok = 1'b1;
        end
    end
    always @(negedge rdclk) begin
        if (rise_ok) begin
            rise_ok = 1'b0;
            n_checks++;
            if (longint'($time) - t_rise != CLK_PERIOD/2) begin
                n_fail++;
                $display("FAIL R4: gated high width got %0d expected %0d",
                         longint'($time) - t_rise, CLK_PERIOD/2);
            end
        end
    end

    // One table row: go, then a sample per cycle against the phase layout.
    task automatic run_row(input int c, input int g, input int w);
        int len;
        len = RST_N_CYC + w + 1 + SET_N_CYC + 1;
        cfg = (c < 0);
        go  = 1'b1;
        tick();
        go  = 1'b0;
        for (int k = 0; k <= len + 1; k++) begin
            if (k < RST_N_CYC)
                check4((g >= 0 && k == g + 1) ? "R2/R6 reset" : "R2 reset", 4'b1001);
            else if (k < RST_N_CYC + w)
                check4((g >= 0 && k == g + 1) ? "R3/R6 wait" : "R3 wait", 4'b0001);
            else if (k < RST_N_CYC + w + 1 + SET_N_CYC)
                check4((g >= 0 && k == g + 1) ? "R4/R6 settle" : "R4 settle", 4'b0101);
            else if (k == RST_N_CYC + w + 1 + SET_N_CYC)
                check4("R5 start", 4'b0111);
            else
                check4("R7 run", 4'b0100);
            if (k == c) cfg = 1'b1;
            go = (k == g);
            tick();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) tick();
        check4("R1 in reset", 4'b0000);
        @(posedge clk);
        #1;
        n_checks++;
        if (rdclk !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: rdclk got %b expected 0", rdclk);
        end
        tick();
        rst_n = 1'b1;
        tick();
        check4("R1 idle", 4'b0000);
        tick();
        check4("R1 idle hold", 4'b0000);

        for (int r = 0; r < NROWS; r++)
            run_row(ROW_CFG[r], ROW_GO[r], ROW_WAIT[r]);

        // R7: go in run restarts; then R1: reset mid-sequence clears all.
        cfg = 1'b0;
        go  = 1'b1;
        tick();
        go  = 1'b0;
        check4("R7 restart", 4'b1001);
        tick();
        check4("R2 restart reset", 4'b1001);
        rst_n = 1'b0;
        tick();
        check4("R1 reset mid-sequence", 4'b0000);
        rst_n = 1'b1;
        tick();
        check4("R1 idle after reset", 4'b0000);
        repeat (3) tick();
        check4("R1 idle stays", 4'b0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule